// File: doc/BRIEF.md
# Delay Reset Sequencer with Status

This block closes each shot of a multi-channel delay generator. It watches the timed-out flags of every delay channel. Once the last channel has finished, it runs a reset cycle of fixed length. The cycle drives three signals:

- a GATE window that spans the whole cycle;
- a LOAD pulse nested inside GATE, used to preset the counters and precharge the ramps;
- a HOLD signal that keeps the channel outputs frozen in their timed-out state.

A processor can also start the same cycle with a reload request after it changes the delay values. In that case HOLD stays low.

Three status bits let a polling processor follow the shot. BUSY is live. TRIGGERED and OVERRUN are sticky and are cleared by a flag-clear input. The default phase lengths (16, 20 and 28 clocks) assume an 80 MHz clock, which gives an 800 ns cycle.

Top module: `dly_reset_seq`

## Requirements
- R1: A normal cycle starts when the AND of all `ch_done_i` bits rises from 0 to 1 while no cycle runs. `gate_o` goes high in the clock cycle after the one in which the AND is first seen high. A partial set of done bits starts nothing.
- R2: `gate_o` stays high for exactly PRE_LEN+LOAD_LEN+POST_LEN clock cycles (64 by default), then falls.
- R3: `load_o` is high only inside GATE. Counting GATE cycles from 0, it is high from cycle PRE_LEN through cycle PRE_LEN+LOAD_LEN-1 (cycles 16 to 35 by default).
- R4: A 0-to-1 transition of `cpu_reload_i`, sampled while no cycle runs, starts the same cycle with the same timing.
- R5: `hold_o` is high for every GATE cycle of a normal cycle and low throughout a cycle started by a reload. If both start conditions occur in the same idle cycle, the cycle counts as normal.
- R6: A start condition (done AND rising, or a reload edge) seen while GATE is high is discarded. A reload held high across the end of a cycle starts no new cycle. The earliest accepted start is in the first cycle after GATE has fallen.
- R7: `busy_o` equals `latch_i` OR `gate_o`, with no delay.
- R8: `triggered_o` becomes 1 in the cycle after any cycle in which `busy_o` is 1, and then stays 1.
- R9: `overrun_o` becomes 1 in the cycle after any cycle in which `trig_i` and `busy_o` are both 1, and then stays 1.
- R10: `flag_clr_i` high in a cycle clears both sticky bits in the next cycle. A set condition in the same cycle wins for that bit.
- R11: While `rst_n` is low, `gate_o`, `load_o`, `hold_o`, `triggered_o` and `overrun_o` are 0. No cycle starts on the first clock after reset unless a start edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger seen this cycle |
| latch_i | input | 1 | Trigger latch active (timing in progress) |
| ch_done_i | input | NUM_CH | Per-channel timed-out flags |
| cpu_reload_i | input | 1 | Processor reload request |
| flag_clr_i | input | 1 | Clear the sticky status bits |
| gate_o | output | 1 | Reset cycle window |
| load_o | output | 1 | Preset pulse inside the window |
| hold_o | output | 1 | Freeze channel outputs (normal cycles only) |
| busy_o | output | 1 | Latch active or cycle running |
| triggered_o | output | 1 | Sticky: busy seen since last clear |
| overrun_o | output | 1 | Sticky: trigger while busy since last clear |

## Verification
A poll clear can land in the same cycle as an event that sets a sticky bit. The bench provokes this in three ways:

- it pulses `flag_clr_i` while a reset cycle keeps `busy_o` high;
- it pulses `flag_clr_i` together with a trigger during that window;
- it pulses `flag_clr_i` alone while idle.

A behavioural model, which lets the set win, is compared with both flags on every clock. The two start sources are also made to coincide in one idle cycle, and that cycle must come out with HOLD high.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_LOAD = 2'd2,
    PH_POST = 2'd3
  } phase_e;
endpackage

// File: rtl/dly_start_arb.sv
module dly_start_arb #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic              cpu_reload_i,
  input  logic              idle_i,
  output logic              start_o,
  output logic              norm_o
);
  logic all_done;
  logic done_q, done_d;
  logic rel_q, rel_d;
  logic norm_edge, cpu_edge;

  always_comb begin
    all_done  = &ch_done_i;
    norm_edge = all_done & ~done_q;
    cpu_edge  = cpu_reload_i & ~rel_q;
    done_d    = all_done;
    rel_d     = cpu_reload_i;
    start_o   = idle_i & (norm_edge | cpu_edge);
    norm_o    = idle_i & norm_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      rel_q  <= rel_d;
    end
  end

  // R1: a normal start needs every channel done
  assert_norm_all_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    norm_o |-> all_done);
  // R6: nothing starts while a cycle runs
  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |-> !start_o);
endmodule

// File: rtl/dly_phase_timer.sv
module dly_phase_timer
  import dly_pkg::*;
#(
  parameter int PRE_LEN  = 16,
  parameter int LOAD_LEN = 20,
  parameter int POST_LEN = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic norm_i,
  output logic idle_o,
  output logic gate_o,
  output logic load_o,
  output logic hold_o
);
  localparam int MAX_A    = (PRE_LEN > LOAD_LEN) ? PRE_LEN : LOAD_LEN;
  localparam int MAX_LEN  = (MAX_A > POST_LEN) ? MAX_A : POST_LEN;
  localparam int CW       = $clog2(MAX_LEN + 1);
  localparam int TOTAL    = PRE_LEN + LOAD_LEN + POST_LEN;
  localparam int GW       = $clog2(TOTAL + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_q, hold_d;
  logic          cnt_zero;

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    cnt_zero = (cnt_q == '0);
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d   = PH_PRE;
          cnt_d  = CW'(PRE_LEN - 1);
          hold_d = norm_i;
        end
      end
      PH_PRE: begin
        if (cnt_zero) begin
          ph_d  = PH_LOAD;
          cnt_d = CW'(LOAD_LEN - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_LOAD: begin
        if (cnt_zero) begin
          ph_d  = PH_POST;
          cnt_d = CW'(POST_LEN - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_POST: begin
        if (cnt_zero) begin
          ph_d   = PH_IDLE;
          hold_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    idle_o = (ph_q == PH_IDLE);
    gate_o = ~idle_o;
    load_o = (ph_q == PH_LOAD);
    hold_o = hold_q;
  end

  // checker-side window counter for the GATE length
  logic [GW-1:0] glen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glen_q <= '0;
    else if (gate_o) glen_q <= glen_q + 1'b1;
    else             glen_q <= '0;
  end

  // R2: GATE lasts exactly the sum of the phases
  assert_gate_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> (glen_q == GW'(TOTAL)));
  // R3: LOAD nests inside GATE
  assert_load_in_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> gate_o);
  // R5: HOLD only inside GATE, steady through the cycle
  assert_hold_in_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> gate_o);
  assert_hold_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && $past(gate_o)) |-> $stable(hold_o));
endmodule

// File: rtl/dly_status_flags.sv
module dly_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic latch_i,
  input  logic gate_i,
  input  logic flag_clr_i,
  output logic busy_o,
  output logic triggered_o,
  output logic overrun_o
);
  logic trg_q, trg_d;
  logic ovr_q, ovr_d;
  logic ovr_set;

  always_comb begin
    busy_o  = latch_i | gate_i;
    ovr_set = trig_i & busy_o;
    trg_d   = busy_o  | (trg_q & ~flag_clr_i);
    ovr_d   = ovr_set | (ovr_q & ~flag_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      trg_q <= trg_d;
      ovr_q <= ovr_d;
    end
  end

  assign triggered_o = trg_q;
  assign overrun_o   = ovr_q;

  // R8: busy is remembered
  assert_trig_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> triggered_o);
  // R9: trigger during busy flags an overrun
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_o) |=> overrun_o);
  // R10: a clear with no set event empties both flags
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !busy_o) |=> (!triggered_o && !overrun_o));
endmodule

// File: rtl/dly_reset_seq.sv
module dly_reset_seq #(
  parameter int NUM_CH   = 5,
  parameter int PRE_LEN  = 16,
  parameter int LOAD_LEN = 20,
  parameter int POST_LEN = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              latch_i,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic              cpu_reload_i,
  input  logic              flag_clr_i,
  output logic              gate_o,
  output logic              load_o,
  output logic              hold_o,
  output logic              busy_o,
  output logic              triggered_o,
  output logic              overrun_o
);
  logic idle;
  logic start;
  logic norm;

  dly_start_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_done_i    (ch_done_i),
    .cpu_reload_i (cpu_reload_i),
    .idle_i       (idle),
    .start_o      (start),
    .norm_o       (norm)
  );

  dly_phase_timer #(
    .PRE_LEN  (PRE_LEN),
    .LOAD_LEN (LOAD_LEN),
    .POST_LEN (POST_LEN)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .norm_i  (norm),
    .idle_o  (idle),
    .gate_o  (gate_o),
    .load_o  (load_o),
    .hold_o  (hold_o)
  );

  dly_status_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .latch_i     (latch_i),
    .gate_i      (gate_o),
    .flag_clr_i  (flag_clr_i),
    .busy_o      (busy_o),
    .triggered_o (triggered_o),
    .overrun_o   (overrun_o)
  );

  // R4: an accepted start raises GATE on the next edge
  assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> gate_o);
endmodule

// File: tb/dly_reset_seq_tb_top.sv
module dly_reset_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 5;
  localparam int PRE   = 16;
  localparam int LDL   = 20;
  localparam int POST  = 28;
  localparam int TOTAL = PRE + LDL + POST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, latch = 1'b0, rel = 1'b0, clr = 1'b0;
  logic [NCH-1:0] done = '0;
  logic gate, load, hold, busy, trgd, ovr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // behavioural reference state
  int m_left = 0, m_age = 0;
  bit m_hold = 0, m_done_q = 0, m_rel_q = 0, m_trg = 0, m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_reset_seq #(.NUM_CH(NCH), .PRE_LEN(PRE), .LOAD_LEN(LDL), .POST_LEN(POST)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .latch_i(latch), .ch_done_i(done),
    .cpu_reload_i(rel), .flag_clr_i(clr), .gate_o(gate), .load_o(load),
    .hold_o(hold), .busy_o(busy), .triggered_o(trgd), .overrun_o(ovr)
  );

  always @(posedge clk) begin
    bit alld, ns, cs, mbusy;
    if (!rst_n) begin
      m_left = 0; m_age = 0; m_hold = 0; m_done_q = 0; m_rel_q = 0; m_trg = 0; m_ovr = 0;
    end else begin
      alld  = &done;
      ns    = alld && !m_done_q;
      cs    = rel && !m_rel_q;
      mbusy = latch || (m_left > 0);
      m_trg = mbusy || (m_trg && !clr);
      m_ovr = (trig && mbusy) || (m_ovr && !clr);
      if (m_left == 0 && (ns || cs)) begin
        m_left = TOTAL; m_age = 0; m_hold = ns;
      end else if (m_left > 0) begin
        m_left--; m_age++;
        if (m_left == 0) m_hold = 0;
      end
      m_done_q = alld;
      m_rel_q  = rel;
    end
  end

  function automatic bit e_gate(); return m_left > 0; endfunction
  function automatic bit e_load(); return (m_left > 0) && m_age >= PRE && m_age < PRE + LDL; endfunction

  task automatic cmp(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "gate_o",      gate, e_gate());
    cmp(tag, "load_o",      load, e_load());
    cmp(tag, "hold_o",      hold, m_hold && e_gate());
    cmp(tag, "busy_o",      busy, latch || e_gate());
    cmp(tag, "triggered_o", trgd, m_trg);
    cmp(tag, "overrun_o",   ovr,  m_ovr);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R2", "gate_o",      gate, e_gate());
      cmp("R3", "load_o",      load, e_load());
      cmp("R5", "hold_o",      hold, m_hold && e_gate());
      cmp("R7", "busy_o",      busy, latch || e_gate());
      cmp("R8", "triggered_o", trgd, m_trg);
      cmp("R9", "overrun_o",   ovr,  m_ovr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    @(negedge clk);
    cmp("R11", "gate_o", gate, 1'b0);
    cmp("R11", "load_o", load, 1'b0);
    cmp("R11", "hold_o", hold, 1'b0);
    cmp("R11", "triggered_o", trgd, 1'b0);
    cmp("R11", "overrun_o", ovr, 1'b0);
    tick(1); rst_n = 1'b1;
    tick(2); @(negedge clk); check_all("R11");

    // partial done set, then full set: normal cycle
    for (int i = 0; i < NCH - 1; i++) begin
      tick(1); done[i] = 1'b1;
    end
    tick(2); @(negedge clk); cmp("R1", "gate_o partial", gate, 1'b0);
    tick(1); done[NCH-1] = 1'b1;
    tick(1); @(negedge clk); cmp("R1", "gate_o start", gate, 1'b1);
    cmp("R5", "hold_o normal", hold, 1'b1);
    tick(PRE); @(negedge clk); check_all("R3");
    // re-raise done AND and send a reload during the running cycle
    done = '0; tick(1); done = '1; rel = 1'b1;
    tick(2); @(negedge clk); check_all("R6");
    tick(TOTAL); @(negedge clk);
    cmp("R6", "gate_o after ignored", gate, 1'b0);
    rel = 1'b0; done = '0;
    tick(3);

    // reload-started cycle, trigger while busy
    tick(1); rel = 1'b1; tick(1); rel = 1'b0;
    @(negedge clk); cmp("R4", "gate_o reload", gate, 1'b1);
    cmp("R5", "hold_o reload", hold, 1'b0);
    tick(5); clr = 1'b1; tick(1); clr = 1'b0;  // clear during busy: set wins
    @(negedge clk); check_all("R10");
    tick(3); trig = 1'b1; clr = 1'b1; tick(1); trig = 1'b0; clr = 1'b0;
    @(negedge clk); check_all("R10");
    tick(TOTAL);
    tick(2); clr = 1'b1; tick(1); clr = 1'b0;
    @(negedge clk); cmp("R10", "triggered_o cleared", trgd, 1'b0);
    cmp("R10", "overrun_o cleared", ovr, 1'b0);

    // latch only, trigger while latched
    tick(1); latch = 1'b1; tick(2); trig = 1'b1; tick(1); trig = 1'b0;
    @(negedge clk); check_all("R9");
    tick(2); latch = 1'b0; trig = 1'b1; tick(1); trig = 1'b0;
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    @(negedge clk); check_all("R8");

    // both starts in the same idle cycle: normal wins
    tick(1); done = '1; rel = 1'b1; tick(1); rel = 1'b0;
    @(negedge clk); cmp("R5", "hold_o both", hold, 1'b1);
    // back-to-back: reload edge in first idle cycle after GATE
    tick(TOTAL - 2); done = '0; rel = 1'b1;
    tick(1); @(negedge clk); check_all("R6");
    tick(1); @(negedge clk); check_all("R6");
    rel = 1'b0;
    tick(TOTAL + 5); @(negedge clk); check_all("R2");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule